// File: doc/BRIEF.md
# Power-up Fuse Trim Loader

This block copies the states of a bank of one-time fuses into volatile trim flip-flops every time the device is enabled with a good supply. The trim word it produces drives the weighted current sinks of an analog adjustment DAC. Until a complete fuse read has been latched and a settling wait has run out, the block holds the rest of the device in a not-ready state.

The sequence is a handshake with the analog fuse-sense circuit. The loader raises a sense request and waits for the done strobe. It takes the fuse states in the following cycle. It then counts a programmable number of clock cycles before it releases ready. The fuse result is held by the sense circuit, not queued, so no valid/ready stream applies: `sense_done` and `fuse_bits` must stay steady while `sense_req` is high, and the loader never applies back-pressure. Dropping enable or supply-good at any point throws away the trim contents and restarts the whole sequence. The dead time is a cycle counter that is cleared on every entry, so a fast off/on toggle cannot shorten it. If the done strobe never arrives, the block stops in a fault state with ready low.

Top module: `fuse_trim_loader`

## Requirements
- R1: After reset, `dev_ready`, `sense_req` and `sense_err` are 0 and `trim_code` is all zero.
- R2: `sense_req` stays low while `enable` or `supply_ok` is low. From idle, with both held high, `sense_req` rises after the second clock edge. If the block is already waiting on supply, `sense_req` rises one edge after `supply_ok` rises.
- R3: The loaded trim word carries `fuse_bits` in bits [24:0] and zeros in bits [31:25]. The fuse bits are taken on the clock edge after the edge that first samples `sense_done` high during the request.
- R4: With settle length L (`settle_len`, where 0 counts as 1), `dev_ready` rises exactly 1+max(L,1) clock edges after the edge that first samples `sense_done` high.
- R5: `trim_code` reads all zero whenever `dev_ready` is low.
- R6: While `dev_ready` stays high, `trim_code` holds steady. Changes on `fuse_bits` after the load have no effect on it.
- R7: A low `enable` or low `supply_ok` clears `dev_ready` and `sense_req` at the next edge. Once both are high again, ready comes only after a new sense handshake and a full settle wait.
- R8: When `sense_done` is absent for SENSE_TMO clock edges of an active request, `sense_err` rises on the last of those edges, `sense_req` drops and `dev_ready` stays low. Dropping `enable` clears `sense_err`.
- R9: A `sense_done` sampled on the last permitted edge of the request is accepted ahead of the timeout, and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Device enable, level |
| supply_ok | input | 1 | Supply high enough for sensing and logic |
| fuse_bits | input | 25 | Sensed fuse states, valid while `sense_done` is high |
| sense_done | input | 1 | Fuse-sense result complete |
| settle_len | input | 8 | Dead time after the load, in clock cycles |
| sense_req | output | 1 | Request to the fuse-sense circuit |
| trim_code | output | 32 | Trim word to the current-sink DAC |
| dev_ready | output | 1 | Release of the rest of the device |
| sense_err | output | 1 | Fuse-sense timeout fault |

## Verification
Two events can land on the same clock edge: the done strobe and the expiry of the sense timeout. The bench delays `sense_done` until exactly the last permitted request cycle. It then expects no error and a normal, correctly timed release of ready. A second collision is an enable glitch in the middle of the settle wait. Here the bench judges that the restart wins. It checks that ready stays low with trim zero until a fresh handshake has been made, and that the full settle length is counted again.

// File: rtl/fuse_trim_pkg.sv
package fuse_trim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_SUPPLY,
    ST_SENSE,
    ST_LATCH,
    ST_SETTLE,
    ST_READY,
    ST_FAULT
  } trim_state_t;
endpackage

// File: rtl/fuse_trim_timer.sv
// Cycle counter: cleared synchronously, advances while enabled.
module fuse_trim_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (advance) count <= count + 1'b1;
  end
endmodule

// File: rtl/fuse_trim_seq.sv
// Load sequence state machine.
module fuse_trim_seq
  import fuse_trim_pkg::*;
#(
  parameter int SENSE_TMO = 64,
  parameter int TMO_W     = 7,
  parameter int SET_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             supply_ok,
  input  logic             sense_done,
  input  logic [TMO_W-1:0] tmo_cnt,
  input  logic [SET_W-1:0] set_cnt,
  input  logic [SET_W-1:0] settle_len,
  output trim_state_t      state
);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(SENSE_TMO - 1);

  trim_state_t nxt;
  logic        settle_done;

  // Zero length behaves as one cycle.
  assign settle_done = ({1'b0, set_cnt} + 1'b1) >= {1'b0, settle_len};

  always_comb begin
    nxt = state;
    if (!enable) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:        nxt = ST_WAIT_SUPPLY;
        ST_WAIT_SUPPLY: if (supply_ok) nxt = ST_SENSE;
        ST_SENSE: begin
          if (!supply_ok)               nxt = ST_IDLE;
          else if (sense_done)          nxt = ST_LATCH;
          else if (tmo_cnt == TMO_LAST) nxt = ST_FAULT;
        end
        ST_LATCH:  nxt = supply_ok ? ST_SETTLE : ST_IDLE;
        ST_SETTLE: begin
          if (!supply_ok)       nxt = ST_IDLE;
          else if (settle_done) nxt = ST_READY;
        end
        ST_READY:  if (!supply_ok) nxt = ST_IDLE;
        ST_FAULT:  if (!supply_ok) nxt = ST_IDLE;
        default:   nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/fuse_trim_loader.sv
// Top: fuse-to-trim loader with gated ready release.
module fuse_trim_loader
  import fuse_trim_pkg::*;
#(
  parameter int FUSE_W    = 25,
  parameter int TRIM_W    = 32,
  parameter int SET_W     = 8,
  parameter int SENSE_TMO = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              supply_ok,
  input  logic [FUSE_W-1:0] fuse_bits,
  input  logic              sense_done,
  input  logic [SET_W-1:0]  settle_len,
  output logic              sense_req,
  output logic [TRIM_W-1:0] trim_code,
  output logic              dev_ready,
  output logic              sense_err
);
  localparam int TMO_W = $clog2(SENSE_TMO + 1);

  trim_state_t       state;
  logic [TMO_W-1:0]  tmo_cnt;
  logic [SET_W-1:0]  set_cnt;
  logic [TRIM_W-1:0] fuse_ext;
  logic [TRIM_W-1:0] trim_q;

  generate
    if (TRIM_W > FUSE_W) begin : g_pad
      assign fuse_ext = {{(TRIM_W - FUSE_W){1'b0}}, fuse_bits};
    end else begin : g_cut
      assign fuse_ext = fuse_bits[TRIM_W-1:0];
    end
  endgenerate

  fuse_trim_seq #(
    .SENSE_TMO (SENSE_TMO),
    .TMO_W     (TMO_W),
    .SET_W     (SET_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .supply_ok  (supply_ok),
    .sense_done (sense_done),
    .tmo_cnt    (tmo_cnt),
    .set_cnt    (set_cnt),
    .settle_len (settle_len),
    .state      (state)
  );

  fuse_trim_timer #(.CNT_W(TMO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (state != ST_SENSE),
    .advance (1'b1),
    .count   (tmo_cnt)
  );

  fuse_trim_timer #(.CNT_W(SET_W)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (state != ST_SETTLE),
    .advance (1'b1),
    .count   (set_cnt)
  );

  // Volatile trim store: lost in idle, written only in the latch state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 trim_q <= '0;
    else if (state == ST_IDLE)  trim_q <= '0;
    else if (state == ST_LATCH) trim_q <= fuse_ext;
  end

  assign sense_req = (state == ST_SENSE) || (state == ST_LATCH);
  assign dev_ready = (state == ST_READY);
  assign sense_err = (state == ST_FAULT);
  assign trim_code = dev_ready ? trim_q : '0;
endmodule

// File: rtl/fuse_trim_chk.sv
// Property checker, bound to the loader.
module fuse_trim_chk #(
  parameter int TRIM_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              supply_ok,
  input logic              sense_done,
  input logic              sense_req,
  input logic [TRIM_W-1:0] trim_code,
  input logic              dev_ready,
  input logic              sense_err
);
  // Set once a handshake completes in the current power-up.
  logic hs_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hs_seen <= 1'b0;
    else if (!enable || !supply_ok)  hs_seen <= 1'b0;
    else if (sense_req && sense_done) hs_seen <= 1'b1;
  end

  AST_READY_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ready |-> hs_seen); // R4
  AST_ABORT_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || !supply_ok) |=> (!dev_ready && !sense_req)); // R7
  AST_TRIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ready && $past(dev_ready)) |-> $stable(trim_code)); // R6
  AST_ERR_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    sense_err |-> (!dev_ready && !sense_req)); // R8
  AST_NO_REQ_WITHOUT_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && !sense_req) |=> !sense_req); // R2
endmodule

bind fuse_trim_loader fuse_trim_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .supply_ok  (supply_ok),
  .sense_done (sense_done),
  .sense_req  (sense_req),
  .trim_code  (trim_code),
  .dev_ready  (dev_ready),
  .sense_err  (sense_err)
);

// File: tb/fuse_trim_loader_test.sv
module fuse_trim_loader_test;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        supply_ok = 1'b0;
  logic [24:0] fuse_bits = '0;
  logic        sense_done = 1'b0;
  logic [7:0]  settle_len = 8'd5;
  logic        sense_req;
  logic [31:0] trim_code;
  logic        dev_ready;
  logic        sense_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fuse_trim_loader #(.SENSE_TMO(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .supply_ok(supply_ok),
    .fuse_bits(fuse_bits), .sense_done(sense_done), .settle_len(settle_len),
    .sense_req(sense_req), .trim_code(trim_code), .dev_ready(dev_ready),
    .sense_err(sense_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // Drop both controls and let the block return to idle.
  task automatic power_down();
    @(negedge clk); enable = 1'b0; supply_ok = 1'b0; sense_done = 1'b0;
    tick(2);
  endtask

  // Power up and wait for the sense request; returns edges waited.
  task automatic power_up(output int n);
    @(negedge clk); enable = 1'b1; supply_ok = 1'b1;
    n = 0;
    while (!sense_req && n < 50) begin tick(1); n++; end
  endtask

  // Give a sense result, return edges until ready (hold done during request).
  task automatic answer(input logic [24:0] f, output int n);
    @(negedge clk); fuse_bits = f; sense_done = 1'b1;
    n = 0;
    while (!dev_ready && n < 400) begin
      tick(1); n++;
      if (!sense_req) sense_done = 1'b0;
      if (!dev_ready) check("R5 trim zero while not ready", trim_code, 32'h0);
    end
  endtask

  task automatic t_reset();
    check("R1 ready", {31'b0, dev_ready}, 32'h0);
    check("R1 req", {31'b0, sense_req}, 32'h0);
    check("R1 err", {31'b0, sense_err}, 32'h0);
    check("R1 trim", trim_code, 32'h0);
  endtask

  task automatic t_supply_gate();
    int n;
    power_up(n);
    check("R2 request two edges after power-up", n, 2);
    power_down();
    @(negedge clk); enable = 1'b1; supply_ok = 1'b0;
    tick(30);
    check("R2 no request without supply", {31'b0, sense_req}, 32'h0);
    @(negedge clk); supply_ok = 1'b1;
    tick(1);
    check("R2 request one edge after supply", {31'b0, sense_req}, 32'h1);
    power_down();
  endtask

  task automatic t_load(input logic [7:0] len, input logic [24:0] f);
    int n, lv;
    settle_len = len;
    lv = (len == 0) ? 1 : int'(len);
    power_up(n);
    answer(f, n);
    check("R4 ready timing", n, 2 + lv);
    check("R3 trim word", trim_code, {7'b0, f});
    @(negedge clk); fuse_bits = ~f;
    tick(5);
    check("R6 trim ignores later fuse change", trim_code, {7'b0, f});
    check("R6 ready held", {31'b0, dev_ready}, 32'h1);
    power_down();
    check("R7 ready cleared by power-down", {31'b0, dev_ready}, 32'h0);
  endtask

  task automatic t_glitch();
    int n;
    settle_len = 8'd20;
    power_up(n);
    @(negedge clk); fuse_bits = 25'h0ABCDE; sense_done = 1'b1;
    tick(3);
    sense_done = 1'b0;
    tick(3);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    tick(1);
    check("R7 ready low after glitch", {31'b0, dev_ready}, 32'h0);
    n = 0;
    while (!sense_req && n < 20) begin tick(1); n++; end
    check("R7 request raised again", {31'b0, sense_req}, 32'h1);
    tick(10);
    check("R7 no ready without new handshake", {31'b0, dev_ready}, 32'h0);
    check("R7 trim zero during restart", trim_code, 32'h0);
    answer(25'h1234567, n);
    check("R7 full settle after restart", n, 22);
    check("R7 new trim value", trim_code, 32'h01234567);
    power_down();
  endtask

  task automatic t_timeout();
    int n;
    settle_len = 8'd3;
    power_up(n);
    tick(TMO - 1);
    check("R8 no error before limit", {31'b0, sense_err}, 32'h0);
    tick(1);
    check("R8 error at limit", {31'b0, sense_err}, 32'h1);
    check("R8 request dropped", {31'b0, sense_req}, 32'h0);
    tick(20);
    check("R8 ready stays low", {31'b0, dev_ready}, 32'h0);
    @(negedge clk); enable = 1'b0;
    tick(1);
    check("R8 error cleared by enable", {31'b0, sense_err}, 32'h0);
    power_down();
  endtask

  task automatic t_done_at_limit();
    int n;
    settle_len = 8'd3;
    power_up(n);
    tick(TMO - 1);
    answer(25'h155AA55, n);
    check("R9 done at limit accepted", n, 5);
    check("R9 no error", {31'b0, sense_err}, 32'h0);
    check("R9 trim word", trim_code, 32'h0155AA55);
    power_down();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    tick(2);
    t_reset();
    t_supply_gate();
    t_load(8'd5, 25'h1A55A3C);
    t_load(8'd0, 25'h0000001);
    t_load(8'd12, 25'h1FFFFFF);
    t_glitch();
    t_timeout();
    t_done_at_limit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule